// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block is the combinational execute stage of a 32-bit three-operand integer pipeline. It receives a fixed-width 32-bit instruction word together with the two source operand values, which the register file has already read. It decodes the major opcode and, for register-register instructions, the function code. It then produces the 32-bit result, the index of the destination register and a write enable for the write-back stage.

The supported register-register operations are add, subtract, AND, OR and signed set-on-less-than. The supported immediate operations are add, signed set-on-less-than, AND, OR and load-upper. Any other encoding is flagged as illegal and produces no register write. Register 0 is hard-wired to zero, so a write aimed at index 0 is never enabled.

Top module: `ex_unit`

## Requirements
- R1: A register-register instruction (opcode bits 31:26 equal 0) with function code (bits 5:0) 32 gives result = a + b modulo 2^32, and its destination is bits 15:11.
- R2: Function code 34 with opcode 0 gives result = a - b modulo 2^32.
- R3: Function codes 36 and 37 with opcode 0 give the bitwise AND and the bitwise OR of a and b.
- R4: Function code 42 with opcode 0 gives 1 when a is less than b as signed two's-complement numbers, and 0 otherwise; bits 31:1 are always 0.
- R5: Opcode 8 gives a plus the sign-extended 16-bit immediate (bits 15:0), with destination bits 20:16; operand b has no effect.
- R6: Opcode 10 gives 1 when a is less than the sign-extended immediate as signed numbers, and 0 otherwise; the destination is bits 20:16.
- R7: Opcodes 12 and 13 give the AND and the OR of a with the zero-extended immediate; the destination is bits 20:16.
- R8: Opcode 15 gives the immediate in bits 31:16 and zeros in bits 15:0, regardless of a and b.
- R9: Write enable is 0 whenever the destination index is 0, and 1 for every legal instruction with a non-zero destination.
- R10: Any other opcode, or opcode 0 with any other function code, raises the illegal flag, clears write enable and drives the result to 0; legal instructions keep the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 32 | First source operand value (register selected by bits 25:21) |
| src_b_i | input | 32 | Second source operand value (register selected by bits 20:16) |
| result_o | output | 32 | Execute result |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| illegal_o | output | 1 | Unrecognised instruction flag |

## Verification
The hardest cases are the signed comparisons at the sign boundary. Examples are 0x7FFFFFFF against 0x80000000, and an immediate of 0x8000 that must become a large negative number. An unsigned comparison or a missing sign extension gives the wrong answer only on these pairs. The bench therefore crosses every operation with a fixed set of extreme operand and immediate values. This set includes both sign limits, all-ones, zero and one. The destination field is also walked through index 0, so the write-enable suppression is met inside the same sweep. Separate sweeps over all 64 opcodes and all 64 function codes reach every illegal encoding.

// File: rtl/ex_pkg.sv
package ex_pkg;

  localparam int unsigned OPC_W   = 6;
  localparam int unsigned REGI_W  = 5;
  localparam int unsigned IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

  localparam logic [OPC_W-1:0] FN_ADD = 6'd32;
  localparam logic [OPC_W-1:0] FN_SUB = 6'd34;
  localparam logic [OPC_W-1:0] FN_AND = 6'd36;
  localparam logic [OPC_W-1:0] FN_OR  = 6'd37;
  localparam logic [OPC_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT,
    ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_ZERO,
    IMM_SIGN,
    IMM_UPPER
  } imm_kind_e;

  typedef struct packed {
    logic      legal;
    logic      use_imm;
    logic      dest_rd;
    imm_kind_e imm_kind;
    alu_op_e   alu_op;
  } ex_ctrl_t;

endpackage

// File: rtl/ex_decode.sv
module ex_decode
  import ex_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [OPC_W-1:0] funct_i,
  output ex_ctrl_t         ctrl_o
);

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.alu_op   = ALU_ADD;
    ctrl_o.imm_kind = IMM_ZERO;
    unique case (opcode_i)
      OPC_REG: begin
        ctrl_o.dest_rd = 1'b1;
        ctrl_o.legal   = 1'b1;
        unique case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.legal  = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        ctrl_o.legal    = 1'b1;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.imm_kind = IMM_SIGN;
        ctrl_o.alu_op   = ALU_ADD;
      end
      OPC_SLTI: begin
        ctrl_o.legal    = 1'b1;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.imm_kind = IMM_SIGN;
        ctrl_o.alu_op   = ALU_SLT;
      end
      OPC_ANDI: begin
        ctrl_o.legal    = 1'b1;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.imm_kind = IMM_ZERO;
        ctrl_o.alu_op   = ALU_AND;
      end
      OPC_ORI: begin
        ctrl_o.legal    = 1'b1;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.imm_kind = IMM_ZERO;
        ctrl_o.alu_op   = ALU_OR;
      end
      OPC_LUI: begin
        ctrl_o.legal    = 1'b1;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.imm_kind = IMM_UPPER;
        ctrl_o.alu_op   = ALU_PASSB;
      end
      default: ctrl_o.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/ex_immgen.sv
module ex_immgen
  import ex_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  imm_kind_e         kind_i,
  output logic [DATA_W-1:0] imm_o
);

  localparam int unsigned EXT_W = DATA_W - IMM_W;

  always_comb begin
    unique case (kind_i)
      IMM_SIGN:  imm_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      IMM_UPPER: imm_o = {imm_i, {EXT_W{1'b0}}};
      default:   imm_o = {{EXT_W{1'b0}}, imm_i};
    endcase
  end

endmodule

// File: rtl/ex_alu.sv
module ex_alu
  import ex_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] y_o
);

  logic less;
  assign less = $signed(a_i) < $signed(b_i);

  always_comb begin
    unique case (op_i)
      ALU_ADD:   y_o = a_i + b_i;
      ALU_SUB:   y_o = a_i - b_i;
      ALU_AND:   y_o = a_i & b_i;
      ALU_OR:    y_o = a_i | b_i;
      ALU_SLT:   y_o = {{(DATA_W-1){1'b0}}, less};
      default:   y_o = b_i;
    endcase
  end

endmodule

// File: rtl/ex_unit.sv
module ex_unit
  import ex_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [31:0]        instr_i,
  input  logic [DATA_W-1:0]  src_a_i,
  input  logic [DATA_W-1:0]  src_b_i,
  output logic [DATA_W-1:0]  result_o,
  output logic [REGI_W-1:0]  dest_o,
  output logic               wr_en_o,
  output logic               illegal_o
);

  ex_ctrl_t          ctrl;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_y;
  logic              unused_fields;

  assign unused_fields = ^{instr_i[25:21], instr_i[10:6]};

  ex_decode u_dec (
    .opcode_i (instr_i[31:26]),
    .funct_i  (instr_i[5:0]),
    .ctrl_o   (ctrl)
  );

  ex_immgen #(.DATA_W(DATA_W)) u_imm (
    .imm_i  (instr_i[15:0]),
    .kind_i (ctrl.imm_kind),
    .imm_o  (imm_ext)
  );

  assign opnd_b = ctrl.use_imm ? imm_ext : src_b_i;

  ex_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i  (src_a_i),
    .b_i  (opnd_b),
    .op_i (ctrl.alu_op),
    .y_o  (alu_y)
  );

  assign dest_o    = ctrl.dest_rd ? instr_i[15:11] : instr_i[20:16];
  assign illegal_o = ~ctrl.legal;
  assign wr_en_o   = ctrl.legal & (dest_o != '0);
  assign result_o  = ctrl.legal ? alu_y : '0;

endmodule

// File: rtl/ex_unit_chk.sv
module ex_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic [31:0]       instr_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic [DATA_W-1:0] result_o,
  input logic [4:0]        dest_o,
  input logic              wr_en_o,
  input logic              illegal_o
);

  logic unused_chk;
  assign unused_chk = ^{src_a_i, src_b_i};

  always_comb begin
    if (dest_o == 5'd0)
      a_r9_no_write_zero: assert (!wr_en_o);
    if (illegal_o)
      a_r10_illegal_quiet: assert (!wr_en_o && result_o == '0);
    if (!illegal_o && instr_i[31:26] == 6'd15)
      a_r8_lui_shape: assert (result_o[15:0] == 16'h0 && result_o[31:16] == instr_i[15:0]);
    if (!illegal_o && instr_i[31:26] == 6'd0 && instr_i[5:0] == 6'd42)
      a_r4_slt_boolean: assert (result_o[DATA_W-1:1] == '0);
    if (!illegal_o && instr_i[31:26] == 6'd0)
      a_r1_dest_rd: assert (dest_o == instr_i[15:11]);
    if (!illegal_o && instr_i[31:26] != 6'd0)
      a_r5_dest_rt: assert (dest_o == instr_i[20:16]);
  end

endmodule

bind ex_unit ex_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_ex_unit.sv
module tb_ex_unit;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] a;
  logic [31:0] b;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        wr_en;
  logic        illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  ex_unit dut (
    .instr_i   (instr),
    .src_a_i   (a),
    .src_b_i   (b),
    .result_o  (result),
    .dest_o    (dest),
    .wr_en_o   (wr_en),
    .illegal_o (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] vals(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h1234_5678;
      6: return 32'hFFFF_0000;
      default: return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [15:0] imms(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h7FFF;
      4: return 16'h8000;
      5: return 16'h1234;
      6: return 16'h00FF;
      default: return 16'hFF00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s instr=%h a=%h b=%h actual=%h expected=%h", req, instr, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] va, input logic [31:0] vb);
    @(negedge clk);
    instr = i;
    a     = va;
    b     = vb;
    #1;
  endtask

  // Reference arithmetic for the ten legal operations, kind 0..9:
  // add sub and or slt addi slti andi ori lui
  task automatic run_kind(input int k);
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] va, vb, ex, se, ze, w;
        logic [15:0] im;
        logic [4:0]  d;
        string       rq;
        va = vals(i);
        vb = vals(j);
        im = imms(j);
        se = {{16{im[15]}}, im};
        ze = {16'h0, im};
        d  = 5'(i * 8 + j);
        case (k)
          0: begin rq = "R1"; ex = va + vb; w = {6'd0, 5'd3, 5'd4, d, 5'd0, 6'd32}; end
          1: begin rq = "R2"; ex = va - vb; w = {6'd0, 5'd3, 5'd4, d, 5'd0, 6'd34}; end
          2: begin rq = "R3"; ex = va & vb; w = {6'd0, 5'd3, 5'd4, d, 5'd0, 6'd36}; end
          3: begin rq = "R3"; ex = va | vb; w = {6'd0, 5'd3, 5'd4, d, 5'd0, 6'd37}; end
          4: begin rq = "R4"; ex = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
                   w = {6'd0, 5'd3, 5'd4, d, 5'd0, 6'd42}; end
          5: begin rq = "R5"; ex = va + se; w = {6'd8, 5'd2, d, im}; end
          6: begin rq = "R6"; ex = ($signed(va) < $signed(se)) ? 32'd1 : 32'd0;
                   w = {6'd10, 5'd2, d, im}; end
          7: begin rq = "R7"; ex = va & ze; w = {6'd12, 5'd2, d, im}; end
          8: begin rq = "R7"; ex = va | ze; w = {6'd13, 5'd2, d, im}; end
          default: begin rq = "R8"; ex = {im, 16'h0}; w = {6'd15, 5'd2, d, im}; end
        endcase
        // Immediate forms: b is filled with a junk value to show it has no effect
        apply(w, va, (k >= 5) ? ~vals((i + j) % 8) ^ 32'h5A5A_A5A5 : vb);
        check(rq, result, ex);
        check(rq, {27'd0, dest}, {27'd0, d});
        check("R9", {31'd0, wr_en}, {31'd0, d != 5'd0});
        check("R10", {31'd0, illegal}, 32'd0);
      end
    end
  endtask

  initial begin
    instr = '0;
    a     = '0;
    b     = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset-time state: all-zero word is opcode 0 funct 0, an illegal encoding (R10)
    apply(32'h0, 32'h0, 32'h0);
    check("R10", {31'd0, illegal}, 32'd1);
    check("R10", {31'd0, wr_en}, 32'd0);
    check("R10", result, 32'd0);

    // Canonical add: rs=17 rt=18 rd=8 (R1)
    apply(32'h0232_4020, 32'd100, 32'd23);
    check("R1", result, 32'd123);
    check("R1", {27'd0, dest}, 32'd8);
    check("R9", {31'd0, wr_en}, 32'd1);

    for (int k = 0; k < 10; k++) run_kind(k);

    // Load-upper then OR-immediate builds an arbitrary constant (R8, R7)
    apply({6'd15, 5'd0, 5'd9, 16'hDEAD}, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R8", result, 32'hDEAD_0000);
    apply({6'd13, 5'd9, 5'd9, 16'hBEEF}, 32'hDEAD_0000, 32'h0);
    check("R7", result, 32'hDEAD_BEEF);

    // Every opcode with a valid funct, nonzero rd and rt (R10)
    for (int op = 0; op < 64; op++) begin
      bit ok;
      ok = (op == 0) || (op == 8) || (op == 10) || (op == 12) || (op == 13) || (op == 15);
      apply({6'(op), 5'd1, 5'd7, 5'd6, 5'd0, 6'd32}, 32'h1111_1111, 32'h2222_2222);
      check("R10", {31'd0, illegal}, {31'd0, !ok});
      check("R10", {31'd0, wr_en}, {31'd0, ok});
      if (!ok) check("R10", result, 32'd0);
    end

    // Every funct under opcode 0 (R10)
    for (int fn = 0; fn < 64; fn++) begin
      bit ok;
      ok = (fn == 32) || (fn == 34) || (fn == 36) || (fn == 37) || (fn == 42);
      apply({6'd0, 5'd1, 5'd7, 5'd6, 5'd0, 6'(fn)}, 32'h1111_1111, 32'h2222_2222);
      check("R10", {31'd0, illegal}, {31'd0, !ok});
      check("R10", {31'd0, wr_en}, {31'd0, ok});
      if (!ok) check("R10", result, 32'd0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule